// File: doc/BRIEF.md
# Condition Register Field Unit

This block holds a 32-bit condition register made of eight 4-bit fields and carries out field-level operations on it. A 4-bit operation code picks one operation each cycle that the valid strobe is high. The available operations are a masked write of several fields from a 64-bit source, a write or a read of a single field chosen from an 8-bit mask, a read of the whole register, and a copy of four carry and overflow flags into one field. It also offers five operations that turn a condition field or a single condition bit into a 64-bit integer.

Bits are numbered big-endian, counting from 32 for the first condition bit. Field n covers condition bits 4n+32 to 4n+35, so field 0 is the most significant nibble of `cr_o` (`cr_o[31:28]`) and field 7 is `cr_o[3:0]`. Condition bit b+32 is `cr_o[31-b]`. Source bits 4n+32 to 4n+35 are `src_i[31-4n -: 4]`. Mask bit n is `mask_i[n]`.

The register and the result both update on the rising clock edge when `valid_i` is high, so each result appears one cycle after its request. Decoding of instructions happens outside this block.

Top module: `cr_field_unit`

## Requirements
- R1: While `rst_n` is low, the condition register and `result_o` are cleared to zero at the next clock edge.
- R2: Operation code 0 (multi-field write) loads every field n whose `mask_i[n]` is set with `src_i[31-4n -: 4]`. All other fields keep their value, and a zero mask changes nothing.
- R3: Operation code 1 (single-field write) loads only the lowest-numbered field n whose mask bit is set, taking `src_i[31-4n -: 4]`. With a zero mask it loads field 7.
- R4: Operation code 2 (single-field read) returns zero in every bit except the lowest-numbered field n with its mask bit set. That field is copied to `result_o[31-4n -: 4]`, and a zero mask returns zero.
- R5: Operation code 3 (full read) returns 32 zero bits above the 32-bit register.
- R6: Operation code 4 (flag copy) writes `ov_i`, `ov32_i`, `ca_i` and `ca32_i` into field `field_i`, in that order from its first (most significant) bit.
- R7: Operation code 5 (three-way) returns all ones if the first bit of field `field_i` is set. Otherwise it returns 1 if the second bit is set, and 0 if neither is set.
- R8: Operation code 6 returns 1 when condition bit `bit_i`+32 is set and 0 otherwise. Operation code 7 returns the reverse.
- R9: Operation code 8 returns all ones when condition bit `bit_i`+32 is set and 0 otherwise. Operation code 9 returns the reverse.
- R10: The register and `result_o` change only on an edge where `valid_i` is high. The new values are visible after that edge and not before it.
- R11: The read and boolean operations (codes 2, 3 and 5 to 9) leave the register unchanged. The write operations (codes 0, 1 and 4) return a zero result.
- R12: Operation codes 10 to 15 leave the register unchanged and return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| mask_i | input | 8 | Field mask, bit n selects field n |
| field_i | input | 3 | Field index for flag copy and three-way |
| bit_i | input | 5 | Condition bit index for bit tests |
| src_i | input | 64 | Source operand |
| ov_i | input | 1 | Overflow flag |
| ov32_i | input | 1 | 32-bit overflow flag |
| ca_i | input | 1 | Carry flag |
| ca32_i | input | 1 | 32-bit carry flag |
| result_o | output | 64 | Registered result |
| cr_o | output | 32 | Condition register |

## Verification
The assertions check these properties on every cycle:
- The register and the result hold when no request is made.
- Read-only operations leave the register untouched, and write operations return zero.
- A single-field write changes at most one field, and a single-field read leaves at most one nonzero nibble.
- A flag copy lands in the named field, and each boolean result takes only one of its legal encodings.

Some behaviours are visible only in the bench's scenarios:
- Which field wins when several mask bits are set.
- The fallback to field 7 for a single-field write with a zero mask.
- The big-endian placement of source nibbles.
- The exact value of each boolean result for a given register content.

// File: rtl/cr_unit_pkg.sv
package cr_unit_pkg;
  localparam int NFIELD_DEF = 8;
  localparam int FIELD_W_DEF = 4;
  localparam int XLEN_DEF = 64;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_WR_MULTI = 4'd0,
    OP_WR_ONE   = 4'd1,
    OP_RD_ONE   = 4'd2,
    OP_RD_ALL   = 4'd3,
    OP_FLAGS    = 4'd4,
    OP_TRI      = 4'd5,
    OP_BIT      = 4'd6,
    OP_BIT_R    = 4'd7,
    OP_NBIT     = 4'd8,
    OP_NBIT_R   = 4'd9
  } cr_op_e;
endpackage

// File: rtl/cr_field_pick.sv
module cr_field_pick #(
  parameter int NF = 8,
  localparam int IW = $clog2(NF)
) (
  input  logic [NF-1:0] mask,
  output logic [IW-1:0] first_idx,
  output logic          any_set,
  output logic [IW-1:0] wr_idx
);
  always_comb begin
    first_idx = '0;
    any_set   = 1'b0;
    for (int i = NF - 1; i >= 0; i--) begin
      if (mask[i]) begin
        first_idx = IW'(i);
        any_set   = 1'b1;
      end
    end
    wr_idx = any_set ? first_idx : IW'(NF - 1);
  end
endmodule

// File: rtl/cr_next_state.sv
module cr_next_state
  import cr_unit_pkg::*;
#(
  parameter int NF = 8,
  parameter int FW = 4,
  parameter int XLEN = 64,
  localparam int CRW = NF * FW,
  localparam int IW = $clog2(NF)
) (
  input  logic [CRW-1:0]  cr,
  input  cr_op_e          op,
  input  logic [NF-1:0]   mask,
  input  logic [IW-1:0]   wr_idx,
  input  logic [IW-1:0]   field_sel,
  input  logic [XLEN-1:0] src,
  input  logic [FW-1:0]   flags,
  output logic [NF-1:0]   field_we,
  output logic [CRW-1:0]  cr_next
);
  for (genvar n = 0; n < NF; n++) begin : g_field
    localparam int HI = CRW - 1 - FW * n;
    logic [FW-1:0] new_val;
    always_comb begin
      field_we[n] = (op == OP_WR_MULTI && mask[n])
                 || (op == OP_WR_ONE && wr_idx == IW'(n))
                 || (op == OP_FLAGS && field_sel == IW'(n));
      new_val = (op == OP_FLAGS) ? flags : src[HI -: FW];
      cr_next[HI -: FW] = field_we[n] ? new_val : cr[HI -: FW];
    end
  end
endmodule

// File: rtl/cr_bool_gen.sv
module cr_bool_gen
  import cr_unit_pkg::*;
#(
  parameter int NF = 8,
  parameter int FW = 4,
  parameter int XLEN = 64,
  localparam int CRW = NF * FW,
  localparam int IW = $clog2(NF),
  localparam int BW = $clog2(CRW)
) (
  input  logic [CRW-1:0]  cr,
  input  cr_op_e          op,
  input  logic [IW-1:0]   field_sel,
  input  logic [BW-1:0]   bit_sel,
  output logic [XLEN-1:0] res
);
  function automatic logic [FW-1:0] get_field(input logic [CRW-1:0] c, input logic [IW-1:0] n);
    logic [CRW-1:0] s;
    s = c >> (FW * (NF - 1 - int'(n)));
    return s[FW-1:0];
  endfunction

  function automatic logic get_bit(input logic [CRW-1:0] c, input logic [BW-1:0] b);
    logic [CRW-1:0] s;
    s = c >> (CRW - 1 - int'(b));
    return s[0];
  endfunction

  logic [FW-1:0] fld;
  logic          tbit;

  always_comb begin
    fld  = get_field(cr, field_sel);
    tbit = get_bit(cr, bit_sel);
    unique case (op)
      OP_TRI:    res = fld[FW-1] ? '1 : (fld[FW-2] ? XLEN'(1) : '0);
      OP_BIT:    res = XLEN'(tbit);
      OP_BIT_R:  res = XLEN'(!tbit);
      OP_NBIT:   res = tbit ? '1 : '0;
      OP_NBIT_R: res = tbit ? '0 : '1;
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/cr_field_unit.sv
module cr_field_unit
  import cr_unit_pkg::*;
#(
  parameter int NF = NFIELD_DEF,
  parameter int FW = FIELD_W_DEF,
  parameter int XLEN = XLEN_DEF,
  localparam int CRW = NF * FW,
  localparam int IW = $clog2(NF),
  localparam int BW = $clog2(CRW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [NF-1:0]   mask_i,
  input  logic [IW-1:0]   field_i,
  input  logic [BW-1:0]   bit_i,
  input  logic [XLEN-1:0] src_i,
  input  logic            ov_i,
  input  logic            ov32_i,
  input  logic            ca_i,
  input  logic            ca32_i,
  output logic [XLEN-1:0] result_o,
  output logic [CRW-1:0]  cr_o
);
  cr_op_e          op;
  logic [CRW-1:0]  cr_q;
  logic [CRW-1:0]  cr_next;
  logic [NF-1:0]   field_we;
  logic [IW-1:0]   first_idx;
  logic [IW-1:0]   wr_idx;
  logic            any_set;
  logic [XLEN-1:0] bool_res;
  logic [XLEN-1:0] res_next;
  logic [FW-1:0]   rd_field;
  logic [FW-1:0]   flag_vec;

  assign op       = cr_op_e'(op_i);
  assign flag_vec = FW'({ov_i, ov32_i, ca_i, ca32_i});

  cr_field_pick #(.NF(NF)) u_pick (
    .mask      (mask_i),
    .first_idx (first_idx),
    .any_set   (any_set),
    .wr_idx    (wr_idx)
  );

  cr_next_state #(.NF(NF), .FW(FW), .XLEN(XLEN)) u_next (
    .cr        (cr_q),
    .op        (op),
    .mask      (mask_i),
    .wr_idx    (wr_idx),
    .field_sel (field_i),
    .src       (src_i),
    .flags     (flag_vec),
    .field_we  (field_we),
    .cr_next   (cr_next)
  );

  cr_bool_gen #(.NF(NF), .FW(FW), .XLEN(XLEN)) u_bool (
    .cr        (cr_q),
    .op        (op),
    .field_sel (field_i),
    .bit_sel   (bit_i),
    .res       (bool_res)
  );

  function automatic logic [XLEN-1:0] place_field(input logic [FW-1:0] v, input logic [IW-1:0] n);
    return XLEN'(v) << (FW * (NF - 1 - int'(n)));
  endfunction

  always_comb begin
    logic [CRW-1:0] sh;
    sh       = cr_q >> (FW * (NF - 1 - int'(first_idx)));
    rd_field = sh[FW-1:0];
    case (op)
      OP_RD_ONE: res_next = any_set ? place_field(rd_field, first_idx) : '0;
      OP_RD_ALL: res_next = XLEN'(cr_q);
      OP_TRI, OP_BIT, OP_BIT_R, OP_NBIT, OP_NBIT_R: res_next = bool_res;
      default:   res_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q     <= '0;
      result_o <= '0;
    end else if (valid_i) begin
      cr_q     <= cr_next;
      result_o <= res_next;
    end
  end

  assign cr_o = cr_q;
endmodule

// File: rtl/cr_field_unit_chk.sv
module cr_field_unit_chk #(
  parameter int NF = 8,
  parameter int FW = 4,
  parameter int XLEN = 64,
  localparam int CRW = NF * FW,
  localparam int IW = $clog2(NF),
  localparam int BW = $clog2(CRW)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [3:0]      op_i,
  input logic [NF-1:0]   mask_i,
  input logic [IW-1:0]   field_i,
  input logic [BW-1:0]   bit_i,
  input logic            ov_i,
  input logic            ov32_i,
  input logic            ca_i,
  input logic            ca32_i,
  input logic [XLEN-1:0] result_o,
  input logic [CRW-1:0]  cr_o
);
  logic [CRW-1:0] cr_prev;
  logic [NF-1:0]  chg;
  logic [NF-1:0]  res_nz;
  logic           is_ro_op;
  logic           is_wr_op;

  always_ff @(posedge clk) begin
    if (!rst_n) cr_prev <= '0;
    else        cr_prev <= cr_o;
  end

  for (genvar n = 0; n < NF; n++) begin : g_f
    assign chg[n]    = cr_prev[CRW-1-FW*n -: FW] != cr_o[CRW-1-FW*n -: FW];
    assign res_nz[n] = |result_o[CRW-1-FW*n -: FW];
  end

  assign is_ro_op = op_i == 4'd2 || op_i == 4'd3 || (op_i >= 4'd5 && op_i <= 4'd9);
  assign is_wr_op = op_i == 4'd0 || op_i == 4'd1 || op_i == 4'd4;

  function automatic logic [FW-1:0] fld_of(input logic [CRW-1:0] c, input logic [IW-1:0] n);
    logic [CRW-1:0] s;
    s = c >> (FW * (NF - 1 - int'(n)));
    return s[FW-1:0];
  endfunction

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> cr_o == '0 && result_o == '0);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(cr_o) && $stable(result_o));
  p_zero_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 4'd0 && mask_i == '0 |=> $stable(cr_o));
  p_one_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 4'd1 |=> $onehot0(chg));
  p_rd_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 4'd2 |=> result_o[XLEN-1:CRW] == '0 && $onehot0(res_nz));
  p_rd_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 4'd3 |=> result_o == XLEN'($past(cr_o)));
  p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 4'd4 |=>
      fld_of(cr_o, $past(field_i)) == FW'({$past(ov_i), $past(ov32_i), $past(ca_i), $past(ca32_i)}));
  p_tri_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 4'd5 |=> result_o == '0 || result_o == XLEN'(1) || result_o == '1);
  p_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (op_i == 4'd6 || op_i == 4'd7) |=> result_o[XLEN-1:1] == '0);
  p_nbit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (op_i == 4'd8 || op_i == 4'd9) |=> result_o == '0 || result_o == '1);
  p_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && is_ro_op |=> $stable(cr_o));
  p_wr_res_r11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && is_wr_op |=> result_o == '0);
  p_undef_r12: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i >= 4'd10 |=> $stable(cr_o) && result_o == '0);
endmodule

bind cr_field_unit cr_field_unit_chk #(.NF(NF), .FW(FW), .XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .mask_i   (mask_i),
  .field_i  (field_i),
  .bit_i    (bit_i),
  .ov_i     (ov_i),
  .ov32_i   (ov32_i),
  .ca_i     (ca_i),
  .ca32_i   (ca32_i),
  .result_o (result_o),
  .cr_o     (cr_o)
);

// File: tb/tb_cr_field_unit.sv
`timescale 1ns/1ps
module tb_cr_field_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [3:0]  op_i;
  logic [7:0]  mask_i;
  logic [2:0]  field_i;
  logic [4:0]  bit_i;
  logic [63:0] src_i;
  logic        ov_i, ov32_i, ca_i, ca32_i;
  logic [63:0] result_o;
  logic [31:0] cr_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cr_field_unit dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .mask_i(mask_i),
    .field_i(field_i), .bit_i(bit_i), .src_i(src_i), .ov_i(ov_i), .ov32_i(ov32_i),
    .ca_i(ca_i), .ca32_i(ca32_i), .result_o(result_o), .cr_o(cr_o)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [7:0]  mask;
    logic [2:0]  fld;
    logic [4:0]  bt;
    logic [63:0] src;
    logic [3:0]  flg;
    logic [31:0] ecr;
    logic [63:0] eres;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{4'd0, 8'hFF, 3'd0, 5'd0, 64'h0000_0000_1234_5678, 4'h0, 32'h1234_5678, 64'h0, 8'd2},  // R2 all fields
    '{4'd0, 8'h01, 3'd0, 5'd0, 64'hFFFF_FFFF_A000_0000, 4'h0, 32'hA234_5678, 64'h0, 8'd2},  // R2 field 0 only
    '{4'd0, 8'h80, 3'd0, 5'd0, 64'h0000_0000_0000_000B, 4'h0, 32'hA234_567B, 64'h0, 8'd2},  // R2 field 7 only
    '{4'd0, 8'h00, 3'd0, 5'd0, ONES,                    4'h0, 32'hA234_567B, 64'h0, 8'd2},  // R2 zero mask
    '{4'd1, 8'h06, 3'd0, 5'd0, 64'h0000_0000_0CC0_0000, 4'h0, 32'hAC34_567B, 64'h0, 8'd3},  // R3 lowest wins
    '{4'd1, 8'h00, 3'd0, 5'd0, 64'h0000_0000_0000_0009, 4'h0, 32'hAC34_5679, 64'h0, 8'd3},  // R3 fallback 7
    '{4'd2, 8'h0C, 3'd0, 5'd0, ONES, 4'h0, 32'hAC34_5679, 64'h0000_0000_0030_0000, 8'd4},   // R4
    '{4'd2, 8'h00, 3'd0, 5'd0, ONES, 4'h0, 32'hAC34_5679, 64'h0, 8'd4},                     // R4 none
    '{4'd3, 8'h00, 3'd0, 5'd0, 64'h0, 4'h0, 32'hAC34_5679, 64'h0000_0000_AC34_5679, 8'd5},  // R5
    '{4'd4, 8'h00, 3'd3, 5'd0, 64'h0, 4'hA, 32'hAC3A_5679, 64'h0, 8'd6},                    // R6
    '{4'd5, 8'h00, 3'd0, 5'd0, 64'h0, 4'h0, 32'hAC3A_5679, ONES, 8'd7},                     // R7 first bit
    '{4'd5, 8'h00, 3'd4, 5'd0, 64'h0, 4'h0, 32'hAC3A_5679, 64'h1, 8'd7},                    // R7 second bit
    '{4'd5, 8'h00, 3'd2, 5'd0, 64'h0, 4'h0, 32'hAC3A_5679, 64'h0, 8'd7},                    // R7 neither
    '{4'd6, 8'h00, 3'd0, 5'd0, 64'h0, 4'h0, 32'hAC3A_5679, 64'h1, 8'd8},                    // R8
    '{4'd7, 8'h00, 3'd0, 5'd0, 64'h0, 4'h0, 32'hAC3A_5679, 64'h0, 8'd8},                    // R8
    '{4'd6, 8'h00, 3'd0, 5'd1, 64'h0, 4'h0, 32'hAC3A_5679, 64'h0, 8'd8},                    // R8
    '{4'd7, 8'h00, 3'd0, 5'd1, 64'h0, 4'h0, 32'hAC3A_5679, 64'h1, 8'd8},                    // R8
    '{4'd6, 8'h00, 3'd0, 5'd31, 64'h0, 4'h0, 32'hAC3A_5679, 64'h1, 8'd8},                   // R8 last bit
    '{4'd8, 8'h00, 3'd0, 5'd0, 64'h0, 4'h0, 32'hAC3A_5679, ONES, 8'd9},                     // R9
    '{4'd8, 8'h00, 3'd0, 5'd1, 64'h0, 4'h0, 32'hAC3A_5679, 64'h0, 8'd9},                    // R9
    '{4'd9, 8'h00, 3'd0, 5'd0, 64'h0, 4'h0, 32'hAC3A_5679, 64'h0, 8'd9},                    // R9
    '{4'd9, 8'h00, 3'd0, 5'd1, 64'h0, 4'h0, 32'hAC3A_5679, ONES, 8'd9},                     // R9
    '{4'd15, 8'hFF, 3'd0, 5'd0, ONES, 4'hF, 32'hAC3A_5679, 64'h0, 8'd12},                   // R12
    '{4'd4, 8'h00, 3'd7, 5'd0, 64'h0, 4'h0, 32'hAC3A_5670, 64'h0, 8'd6},                    // R6 field 7
    '{4'd2, 8'hF0, 3'd0, 5'd0, 64'h0, 4'h0, 32'hAC3A_5670, 64'h0000_0000_0000_5000, 8'd4}   // R4 field 4
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    valid_i = 1'b1;
    op_i = v.op; mask_i = v.mask; field_i = v.fld; bit_i = v.bt; src_i = v.src;
    {ov_i, ov32_i, ca_i, ca32_i} = v.flg;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; op_i = '0; mask_i = '0; field_i = '0; bit_i = '0;
    src_i = '0; ov_i = 0; ov32_i = 0; ca_i = 0; ca32_i = 0;
    repeat (3) @(negedge clk);
    check(cr_o == 32'h0, "R1 cr after reset", 64'(cr_o), 64'h0);
    check(result_o == 64'h0, "R1 result after reset", result_o, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i]);
      check(cr_o == TBL[i].ecr, $sformatf("R%0d cr vec %0d", TBL[i].req, i), 64'(cr_o), 64'(TBL[i].ecr));
      check(result_o == TBL[i].eres, $sformatf("R%0d res vec %0d", TBL[i].req, i), result_o, TBL[i].eres);
    end

    // R10: no strobe, a full write request must not take effect
    @(negedge clk);
    op_i = 4'd0; mask_i = 8'hFF; src_i = 64'h0; valid_i = 1'b0;
    repeat (2) @(negedge clk);
    check(cr_o == 32'hAC3A_5670, "R10 hold cr", 64'(cr_o), 64'hAC3A_5670);
    check(result_o == 64'h5000, "R10 hold result", result_o, 64'h5000);

    // R10: latency, not visible before the edge, visible after it
    valid_i = 1'b1; op_i = 4'd3;
    #1;
    check(result_o == 64'h5000, "R10 before edge", result_o, 64'h5000);
    @(negedge clk);
    valid_i = 1'b0;
    check(result_o == 64'h0000_0000_AC3A_5670, "R10 after edge", result_o, 64'h0000_0000_AC3A_5670);

    // R11: a write returns zero result
    issue('{4'd1, 8'h80, 3'd0, 5'd0, 64'h3, 4'h0, 32'hAC3A_5673, 64'h0, 8'd11});
    check(cr_o == 32'hAC3A_5673, "R11 write cr", 64'(cr_o), 64'hAC3A_5673);
    check(result_o == 64'h0, "R11 write result zero", result_o, 64'h0);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(cr_o == 32'h0, "R1 mid-run reset cr", 64'(cr_o), 64'h0);
    check(result_o == 64'h0, "R1 mid-run reset result", result_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    finish_run();
  end
endmodule